// File: doc/BRIEF.md
# Buffered Burst Write Master

This block is a memory-write master for a 64-bit high-throughput memory port that speaks the AXI write protocol. A producer hands it one word per cycle, together with a target byte address, through a simple valid-only push input. Every accepted word goes into an internal synchronous FIFO first. The controller does not start a transaction until the FIFO holds a complete burst of 16 words. It then runs one fixed-length incrementing burst, using one channel at a time. The address phase goes first. The data phase follows, and each beat it sends removes one word from the FIFO. Last comes the wait for the write response, and then the block goes back to idle.

The burst address is the address that was pushed together with the first word of that burst. Addresses pushed with the other words are stored but not used. The block reports progress through a busy level and a one-cycle done pulse. It also keeps two sticky flags, one for pushes lost to a full FIFO and one for non-OKAY write responses. These flags clear only on reset.

Top module: `burst_write_master`

## Requirements
- R1: After reset, awvalid, wvalid, bready, busy, done, overflow and bresp_err are all 0.
- R2: awvalid rises only when the FIFO has held at least 16 accepted words at the preceding clock edge. With 15 or fewer words stored, no address phase starts.
- R3: During the address phase, awlen is 15, awsize is 3 (8-byte beats) and awburst is 2'b01 (incrementing). awaddr equals the push address of the oldest word in the FIFO. awvalid and awaddr stay stable until awready is seen.
- R4: wvalid is never high before the address handshake of the current burst has completed, and it is never high in the same cycle as awvalid.
- R5: Each burst carries exactly 16 data beats. wlast is 1 on the 16th beat and 0 on the others, and wstrb is all ones (8'hFF) on every beat.
- R6: wdata carries the accepted words in push order. A word leaves the FIFO only on a cycle with wvalid and wready both high, and wvalid and wdata hold while wready is low.
- R7: bready rises in the cycle after the last data handshake and stays high until the response handshake. One cycle after that handshake, done is 1 for exactly one cycle and busy is 0.
- R8: A response with bresp other than 2'b00 sets bresp_err, and bresp_err stays set. A 2'b00 response leaves it unchanged.
- R9: The FIFO holds 32 words. A push that arrives while it holds 32 words is dropped, never appears on wdata, and sets the sticky overflow flag.
- R10: busy is 1 whenever awvalid, wvalid or bready is 1.
- R11: If the FIFO still holds 16 or more words when a burst finishes, awvalid for the next burst is high one cycle after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push one word this cycle |
| push_data | input | 64 | Word to write |
| push_addr | input | 32 | Byte address carried with the word |
| awaddr | output | 32 | Burst start address |
| awlen | output | 8 | Beats minus one (15) |
| awsize | output | 3 | Bytes per beat as log2 (3) |
| awburst | output | 2 | Burst type, incrementing |
| awvalid | output | 1 | Address valid |
| awready | input | 1 | Address accepted by slave |
| wdata | output | 64 | Write data beat |
| wstrb | output | 8 | Byte enables, all ones |
| wlast | output | 1 | Final beat of the burst |
| wvalid | output | 1 | Data beat valid |
| wready | input | 1 | Data beat accepted by slave |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Master ready for response |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse after the response handshake |
| overflow | output | 1 | Sticky: a push was dropped on a full FIFO |
| bresp_err | output | 1 | Sticky: a non-OKAY response was received |

## Verification
The first directed pattern pushes 15 words and then waits. It shows whether a burst starts early, before the 16-word threshold. A random stream follows, with random producer gaps and random awready, wready and response delays. It separates correct ordering and beat counting from a FIFO that pops on wvalid alone or a burst that starts its next launch late. A burst is then stalled on awready while 40 words arrive, which fills the FIFO, exercises the drop path, and leads to two bursts back to back. A final burst answered with an error response, followed by a clean one, shows that the error flag is set and then kept.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } wr_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/bwm_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with a registered RAM read and a show-ahead head word.
module bwm_fifo #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0]    LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr, raddr;
  logic [WIDTH-1:0] rd_q, wbuf_q;
  logic             byp_q;
  logic             wr_ok, rd_ok;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CAP);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && (count != '0);
  assign raddr = rd_ok ? step_ptr(rd_ptr) : rd_ptr;

  // RAM: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      byp_q  <= 1'b0;
      wbuf_q <= '0;
    end else begin
      if (wr_ok) wr_ptr <= step_ptr(wr_ptr);
      if (rd_ok) rd_ptr <= step_ptr(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      // A write to the location being read lands in the head next cycle.
      byp_q  <= wr_ok && (wr_ptr == raddr);
      wbuf_q <= wr_data;
    end
  end

  assign rd_data = byp_q ? wbuf_q : rd_q;

  // R9: occupancy never exceeds the capacity.
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CAP);
  // R9: a push into a full FIFO without a pop leaves the count unchanged.
  a_r9_drop_full: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (count == $past(count)));
endmodule

// File: rtl/bwm_ctrl.sv
`timescale 1ns/1ps
// Sequencer: address phase, then data beats, then response, one at a time.
module bwm_ctrl
  import bwm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int BEATS  = 16,
  parameter int CNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    fifo_count,
  input  logic [DATA_W-1:0]   head_data,
  input  logic [ADDR_W-1:0]   head_addr,
  output logic                pop,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready,
  output logic                busy,
  output logic                done,
  output logic                resp_err
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0]    LAST_IDX = BW'(BEATS - 1);
  localparam logic [BW-1:0]    PREV_IDX = BW'(BEATS - 2);
  localparam logic [CNT_W-1:0] LAUNCH   = CNT_W'(BEATS);

  wr_state_e     state_q;
  logic [BW-1:0] beat_q;
  logic          aw_hs, w_hs, b_hs;

  assign aw_hs   = awvalid && awready;
  assign w_hs    = wvalid && wready;
  assign b_hs    = bvalid && bready;
  assign pop     = w_hs;
  assign wdata   = head_data;
  assign wstrb   = '1;
  assign awlen   = 8'(BEATS - 1);
  assign awsize  = 3'($clog2(DATA_W / 8));
  assign awburst = BURST_INCR;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      beat_q   <= '0;
      awaddr   <= '0;
      awvalid  <= 1'b0;
      wvalid   <= 1'b0;
      wlast    <= 1'b0;
      bready   <= 1'b0;
      done     <= 1'b0;
      resp_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fifo_count >= LAUNCH) begin
            state_q <= ST_ADDR;
            awvalid <= 1'b1;
            awaddr  <= head_addr;
          end
        end
        ST_ADDR: begin
          if (aw_hs) begin
            state_q <= ST_DATA;
            awvalid <= 1'b0;
            wvalid  <= 1'b1;
            wlast   <= (BEATS == 1);
            beat_q  <= '0;
          end
        end
        ST_DATA: begin
          if (w_hs) begin
            if (beat_q == LAST_IDX) begin
              state_q <= ST_RESP;
              wvalid  <= 1'b0;
              wlast   <= 1'b0;
              bready  <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
              wlast  <= (beat_q == PREV_IDX);
            end
          end
        end
        ST_RESP: begin
          if (b_hs) begin
            state_q <= ST_IDLE;
            bready  <= 1'b0;
            done    <= 1'b1;
            if (bresp != RESP_OKAY) resp_err <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an address phase starts only on a full burst of stored words.
  a_r2_launch_threshold: assert property (@(posedge clk) disable iff (rst)
    $rose(awvalid) |-> ($past(fifo_count) >= LAUNCH));
  // R3: the address request holds until accepted.
  a_r3_aw_hold: assert property (@(posedge clk) disable iff (rst)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));
  // R4: data never overlaps the address phase or the response wait.
  a_r4_w_after_aw: assert property (@(posedge clk) disable iff (rst)
    wvalid |-> (!awvalid && !bready));
  // R5: the final beat ends the data phase and opens the response wait.
  a_r5_last_ends_data: assert property (@(posedge clk) disable iff (rst)
    (w_hs && wlast) |=> (!wvalid && bready));
  // R6: a stalled beat holds its data.
  a_r6_w_hold: assert property (@(posedge clk) disable iff (rst)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));
  // R7: the response handshake produces the done pulse and frees the block.
  a_r7_done_after_b: assert property (@(posedge clk) disable iff (rst)
    b_hs |=> (done && !busy));
  // R8: the error flag never clears.
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    resp_err |=> resp_err);
  // R10: any channel activity implies busy.
  a_r10_busy_cover: assert property (@(posedge clk) disable iff (rst)
    (awvalid || wvalid || bready) |-> busy);
endmodule

// File: rtl/burst_write_master.sv
`timescale 1ns/1ps
module burst_write_master #(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int BURST_LEN  = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_valid,
  input  logic [DATA_W-1:0]   push_data,
  input  logic [ADDR_W-1:0]   push_addr,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready,
  output logic                busy,
  output logic                done,
  output logic                overflow,
  output logic                bresp_err
);
  localparam int ENTRY_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0]   fifo_count;
  logic               fifo_full;
  logic               pop;

  bwm_fifo #(
    .WIDTH (ENTRY_W),
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_valid),
    .wr_data ({push_addr, push_data}),
    .rd_en   (pop),
    .rd_data (head),
    .count   (fifo_count),
    .full    (fifo_full)
  );

  bwm_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BEATS  (BURST_LEN),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fifo_count (fifo_count),
    .head_data  (head[DATA_W-1:0]),
    .head_addr  (head[ENTRY_W-1:DATA_W]),
    .pop        (pop),
    .awaddr     (awaddr),
    .awlen      (awlen),
    .awsize     (awsize),
    .awburst    (awburst),
    .awvalid    (awvalid),
    .awready    (awready),
    .wdata      (wdata),
    .wstrb      (wstrb),
    .wlast      (wlast),
    .wvalid     (wvalid),
    .wready     (wready),
    .bresp      (bresp),
    .bvalid     (bvalid),
    .bready     (bready),
    .busy       (busy),
    .done       (done),
    .resp_err   (bresp_err)
  );

  always_ff @(posedge clk) begin
    if (rst)                           overflow <= 1'b0;
    else if (push_valid && fifo_full)  overflow <= 1'b1;
  end

  // R9: a push into a full FIFO raises the overflow flag.
  a_r9_overflow_set: assert property (@(posedge clk) disable iff (rst)
    (push_valid && fifo_full) |=> overflow);
  // R9: the overflow flag is sticky.
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: tb/test_burst_write_master.sv
`timescale 1ns/1ps
module test_burst_write_master;
  localparam int BURST = 16;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [63:0] push_data = '0;
  logic [31:0] push_addr = '0;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        awvalid, awready = 1'b0;
  logic [63:0] wdata;
  logic [7:0]  wstrb;
  logic        wlast, wvalid, wready = 1'b0;
  logic [1:0]  bresp = 2'b00;
  logic        bvalid = 1'b0;
  logic        bready, busy, done, overflow, bresp_err;

  always #2 clk = ~clk;

  burst_write_master i_burst_write_master (
    .clk(clk), .rst(rst),
    .push_valid(push_valid), .push_data(push_data), .push_addr(push_addr),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .busy(busy), .done(done), .overflow(overflow), .bresp_err(bresp_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state
  logic [63:0] q_data[$];
  logic [31:0] q_addr[$];
  int   model_cnt = 0;
  bit   model_ovf = 0;
  bit   model_err = 0;
  bit   aw_taken = 0;
  int   beat = 0;
  bit   b_pend = 0;
  int   b_delay = 0;
  bit   b_hs_last = 0;
  logic [1:0] next_resp = 2'b00;
  bit   exp_done = 0;
  bit   exp_bready = 0;
  int   launch_in = 0;
  bit   awv_prev = 0;
  bit   hold_aw = 0;
  int   seq = 0;

  function automatic bit exp_wlast(input int b);
    return (b == BURST - 1);
  endfunction

  function automatic bit resp_is_err(input logic [1:0] r);
    return (r != 2'b00);
  endfunction

  function automatic logic [31:0] addr_of(input int s);
    return 32'h0100_0000 + 32'(s * 8);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at a negedge, judge the coming edge, wait a cycle.
  task automatic cyc(input bit pv);
    logic [63:0] d;
    bit w_hs_now, b_hs_now, aw_hs_now;
    d = {$urandom, $urandom};
    push_valid = pv;
    push_data  = d;
    push_addr  = addr_of(seq);
    awready = !hold_aw && ($urandom % 3 != 0);
    wready  = ($urandom % 4 != 0);
    if (b_hs_last) begin bvalid = 1'b0; b_hs_last = 0; end
    if (b_pend && !bvalid) begin
      if (b_delay == 0) begin bvalid = 1'b1; bresp = next_resp; end
      else b_delay--;
    end

    // Output checks reflecting edges so far
    chk(overflow == model_ovf, "R9", "overflow flag", 64'(overflow), 64'(model_ovf));
    if (exp_done) begin
      chk(done == 1'b1, "R7", "done pulse", 64'(done), 64'd1);
      chk(busy == 1'b0, "R7", "busy after response", 64'(busy), 64'd0);
      chk(bresp_err == model_err, "R8", "error flag", 64'(bresp_err), 64'(model_err));
      exp_done = 0;
    end else begin
      chk(done == 1'b0, "R7", "done idle", 64'(done), 64'd0);
    end
    if (launch_in > 0) begin
      launch_in--;
      if (launch_in == 0)
        chk(awvalid == 1'b1, "R11", "back-to-back launch", 64'(awvalid), 64'd1);
    end
    if (exp_bready) begin
      chk(bready == 1'b1, "R7", "bready after last beat", 64'(bready), 64'd1);
      exp_bready = 0;
    end
    if (bready && !(aw_taken && beat == BURST))
      chk(0, "R7", "bready early", 64'(beat), 64'(BURST));
    if (awvalid && !awv_prev)
      chk(model_cnt >= BURST, "R2", "launch occupancy", 64'(model_cnt), 64'(BURST));
    awv_prev = awvalid;
    if (wvalid && (!aw_taken || awvalid))
      chk(0, "R4", "wvalid before address handshake", 64'(wvalid), 64'd0);
    if ((awvalid || wvalid || bready) && !busy)
      chk(0, "R10", "busy low during activity", 64'(busy), 64'd1);

    // Handshakes at the coming edge
    aw_hs_now = awvalid && awready;
    w_hs_now  = wvalid && wready;
    b_hs_now  = bvalid && bready;
    if (aw_hs_now) begin
      chk(awaddr == q_addr[0], "R3", "awaddr", 64'(awaddr), 64'(q_addr[0]));
      chk(awlen == 8'd15, "R3", "awlen", 64'(awlen), 64'd15);
      chk(awsize == 3'd3, "R3", "awsize", 64'(awsize), 64'd3);
      chk(awburst == 2'b01, "R3", "awburst", 64'(awburst), 64'd1);
      aw_taken = 1;
      beat = 0;
    end
    if (w_hs_now) begin
      chk(wdata == q_data[0], "R6", "wdata order", wdata, q_data[0]);
      chk(wstrb == 8'hFF, "R5", "wstrb", 64'(wstrb), 64'hFF);
      chk(wlast == exp_wlast(beat), "R5", "wlast position", 64'(wlast), 64'(exp_wlast(beat)));
      void'(q_data.pop_front());
      void'(q_addr.pop_front());
      beat++;
      if (beat == BURST) begin
        b_pend = 1;
        b_delay = $urandom % 4;
        exp_bready = 1;
      end
    end
    if (b_hs_now) begin
      if (resp_is_err(bresp)) model_err = 1;
      b_pend = 0;
      b_hs_last = 1;
      next_resp = 2'b00;
      aw_taken = 0;
      beat = 0;
      exp_done = 1;
    end
    if (pv) begin
      if (model_cnt < DEPTH) begin
        q_data.push_back(d);
        q_addr.push_back(addr_of(seq));
        model_cnt++;
      end else begin
        model_ovf = 1;
      end
      seq++;
    end
    if (w_hs_now) model_cnt--;
    if (b_hs_now && model_cnt >= BURST) launch_in = 2;

    @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while ((model_cnt >= BURST || aw_taken || b_pend || exp_done || launch_in > 0
            || awvalid) && guard < 2000) begin
      cyc(0);
      guard++;
    end
    cyc(0);
    cyc(0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(awvalid == 0, "R1", "awvalid", 64'(awvalid), 0);
    chk(wvalid == 0, "R1", "wvalid", 64'(wvalid), 0);
    chk(bready == 0, "R1", "bready", 64'(bready), 0);
    chk(busy == 0, "R1", "busy", 64'(busy), 0);
    chk(done == 0, "R1", "done", 64'(done), 0);
    chk(overflow == 0, "R1", "overflow", 64'(overflow), 0);
    chk(bresp_err == 0, "R1", "bresp_err", 64'(bresp_err), 0);

    // R2: 15 words must not launch
    for (int i = 0; i < 15; i++) cyc(1);
    for (int i = 0; i < 20; i++) begin
      chk(awvalid == 0 && busy == 0, "R2", "no launch below threshold",
          64'({awvalid, busy}), 0);
      cyc(0);
    end
    cyc(1);
    cyc(0);
    chk(awvalid == 1, "R2", "launch at threshold", 64'(awvalid), 1);
    drain();

    // Random stream
    for (int i = 0; i < 3000; i++) cyc($urandom % 5 < 3);
    drain();

    // R9: stall the address phase while 40 words arrive
    hold_aw = 1;
    for (int i = 0; i < 40 - model_cnt + model_cnt; i++) cyc(1);
    chk(overflow == 1, "R9", "overflow after 40 pushes", 64'(overflow), 1);
    hold_aw = 0;
    drain();
    chk(model_cnt < BURST && busy == 0, "R9", "drained after overflow",
        64'(busy), 0);

    // R8: error response then clean burst
    next_resp = 2'b10;
    for (int i = 0; i < BURST; i++) cyc(1);
    drain();
    chk(bresp_err == 1, "R8", "error set", 64'(bresp_err), 1);
    for (int i = 0; i < BURST; i++) cyc(1);
    drain();
    chk(bresp_err == 1, "R8", "error kept after OKAY", 64'(bresp_err), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #760000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule